// File: doc/BRIEF.md
# USB Host Port Line-Event Interrupt Unit

This unit watches one USB host port for four events and raises an interrupt for each. It samples the full/low-speed line state and the port's two over-current pins, which reach it without a clock relation. It holds a latched status bit for each of these events: an over-current pin change, a bus state change, a detach and an attach. Each status bit is gated by a software enable bit. Together they drive one active-low interrupt output. Live copies of the line state and of the over-current pins are always available on monitor outputs. Chattering is not filtered in hardware. Software samples the monitors repeatedly when it needs a settled value.

Attach and detach are qualified over a fixed window of 2.5 µs. The window length in cycles comes from a clock-frequency parameter. An attach needs a fresh entry into J or K, from any other state including SE1, followed by an unbroken hold for the whole window. Attach detection is armed only while the port is idle. A detach needs SE0 held for the whole window while the port is attached. When a detach occurs, hardware drops the port-active flag and returns the port to idle at once. It does this whether or not the detach interrupt is enabled.

Software uses one write port with three targets. It can load the enable bits, clear status bits by writing zeros, or set the port-active flag.

Top module: `usb_port_line_irq`

## Requirements
- R1: Status bit 0 (over-current change) sets after any rising or falling edge on either over-current pin.
- R2: `ovc_mon_o` shows {pin B, pin A} as synchronized levels, two clock edges after a pin changes.
- R3: Line encoding is 00 SE0, 01 J, 10 K, 11 SE1. Status bit 1 (bus change) sets when the line moves between two different states among SE0, J and K. A move into or out of SE1 leaves it unchanged.
- R4: `line_mon_o` shows the synchronized line state, two clock edges after the input changes.
- R5: The window length is QUAL = CLK_HZ/400000 cycles. Status bit 3 (attach) sets when the port is idle and the line enters J or K from another state and then holds it for QUAL cycles. Counted from the input change, the bit is still clear after QUAL cycles and is set within QUAL+6 cycles. The port then leaves idle (`port_idle_o` = 0).
- R6: Status bit 2 (detach) sets when the port is attached and the line holds SE0 for QUAL cycles. At the same time `port_active_o` goes to 0 and `port_idle_o` goes to 1, whatever the enable bits hold.
- R7: `irq_n_o` is low exactly when some status bit and its enable bit are both 1.
- R8: A write with `wr_sel_i` = 01 clears each status bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. An event in the same cycle as the clear keeps its bit set.
- R9: While the port is attached, no line sequence sets the attach bit, whatever it is and however long it holds.
- R10: After reset, status and enable are 0, `irq_n_o` is 1, the port is idle, `port_active_o` is 0 and both monitors read 0.
- R11: A write with `wr_sel_i` = 00 loads the four enable bits from `wr_data_i`. A write with `wr_sel_i` = 10 loads `port_active_o` from `wr_data_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 2 | Raw line state (00 SE0, 01 J, 10 K, 11 SE1), asynchronous |
| ovc_a_i | input | 1 | Over-current pin A, asynchronous |
| ovc_b_i | input | 1 | Over-current pin B, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 enable, 01 status clear, 10 port control |
| wr_data_i | input | 4 | Write data |
| irq_n_o | output | 1 | Active-low interrupt |
| line_mon_o | output | 2 | Synchronized line state |
| ovc_mon_o | output | 2 | Synchronized {B, A} over-current levels |
| status_o | output | 4 | Status: bit3 attach, bit2 detach, bit1 bus change, bit0 over-current |
| enable_o | output | 4 | Interrupt enable bits, same bit order as status |
| port_active_o | output | 1 | Port-active flag |
| port_idle_o | output | 1 | 1 while the port is idle (not attached) |

## Verification
A software status clear can land in the same clock cycle as a new event that sets the same bit. The bench toggles an over-current pin and then issues a zero-write clear at each of several cycle offsets after the toggle. Counting the two synchronizer flops and the status register, the event reaches the status register on the third edge. A clear sampled on or before that edge must leave the bit set, and a later clear must leave it at 0. Random line sequences also mix in pin toggles and enable writes, and each step is compared with a bench model of the status, the port state and the interrupt level.

// File: rtl/ulev_pkg.sv
package ulev_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic {
        PORT_IDLE     = 1'b0,
        PORT_ATTACHED = 1'b1
    } port_t;

    typedef enum logic [1:0] {
        WSEL_ENABLE = 2'b00,
        WSEL_CLEAR  = 2'b01,
        WSEL_CTRL   = 2'b10
    } wsel_t;

    // event vector, bit 0 first: ovc, bchg, detach, attach
    typedef struct packed {
        logic attach;
        logic detach;
        logic bchg;
        logic ovc;
    } evt_t;

    localparam int NUM_EVT = 4;

    // 2.5 us expressed in cycles of a CLK_HZ clock (1 / 2.5 us = 400 kHz)
    function automatic int qual_cycles(input int clk_hz);
        int c;
        c = clk_hz / 400000;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic logic is_fs_level(input line_t l);
        return l != LS_SE1;
    endfunction

    function automatic logic is_idle_drive(input line_t l);
        return (l == LS_J) || (l == LS_K);
    endfunction

endpackage

// File: rtl/ulev_sync.sv
module ulev_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ulev_ovc_edge.sv
module ulev_ovc_edge #(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_s,
    output logic            edge_evt
);
    logic [PINS-1:0] pin_q;
    logic [PINS-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_s;
    end

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            assign diff[p] = pin_s[p] ^ pin_q[p];
        end
    endgenerate

    assign edge_evt = |diff;
endmodule

// File: rtl/ulev_line_mon.sv
module ulev_line_mon
    import ulev_pkg::*;
#(
    parameter int QUAL = 312
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t line_s,
    input  port_t port_st,
    output logic  bchg_evt,
    output logic  attach_evt,
    output logic  detach_evt
);
    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL);
    localparam logic [CW-1:0] CNT_FIRE = CW'(QUAL - 1);

    line_t         line_q;
    logic [CW-1:0] run_cnt;
    logic          moved;
    logic          qual_hit;

    assign moved = (line_s != line_q);

    // run counter restarts on every move, saturates once the window is over
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= LS_SE0;
            run_cnt <= CNT_MAX;
        end else begin
            line_q <= line_s;
            if (moved)
                run_cnt <= '0;
            else if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign qual_hit   = !moved && (run_cnt == CNT_FIRE);
    assign bchg_evt   = moved && is_fs_level(line_s) && is_fs_level(line_q);
    assign attach_evt = qual_hit && is_idle_drive(line_s) && (port_st == PORT_IDLE);
    assign detach_evt = qual_hit && (line_s == LS_SE0) && (port_st == PORT_ATTACHED);
endmodule

// File: rtl/ulev_irq_regs.sv
module ulev_irq_regs #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  logic         clr_we,
    input  logic [N-1:0] clr_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq_n
);
    logic [N-1:0] hit;

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    status[b] <= 1'b0;
                    enable[b] <= 1'b0;
                end else begin
                    // set wins over a zero-write clear in the same cycle
                    if (evt[b])
                        status[b] <= 1'b1;
                    else if (clr_we && !clr_wdata[b])
                        status[b] <= 1'b0;
                    if (en_we)
                        enable[b] <= en_wdata[b];
                end
            end
            assign hit[b] = status[b] & enable[b];
        end
    endgenerate

    assign irq_n = ~(|hit);
endmodule

// File: rtl/usb_port_line_irq.sv
module usb_port_line_irq
    import ulev_pkg::*;
#(
    parameter int CLK_HZ      = 125000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_i,
    input  logic       ovc_a_i,
    input  logic       ovc_b_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_sel_i,
    input  logic [3:0] wr_data_i,
    output logic       irq_n_o,
    output logic [1:0] line_mon_o,
    output logic [1:0] ovc_mon_o,
    output logic [3:0] status_o,
    output logic [3:0] enable_o,
    output logic       port_active_o,
    output logic       port_idle_o
);
    localparam int QUAL   = qual_cycles(CLK_HZ);
    localparam int SYNC_W = 4;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_out;
    line_t             line_s;
    logic [1:0]        ovc_s;
    evt_t              evts;
    logic              ovc_evt, bchg_evt, attach_evt, detach_evt;
    port_t             port_st;
    logic              uact;
    wsel_t             wsel;
    logic              en_we, clr_we, ctrl_we;

    assign raw_in = {ovc_b_i, ovc_a_i, line_i};

    ulev_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    assign line_s = line_t'(sync_out[1:0]);
    assign ovc_s  = sync_out[3:2];

    ulev_ovc_edge #(.PINS(2)) u_ovc (
        .clk      (clk),
        .rst      (rst),
        .pin_s    (ovc_s),
        .edge_evt (ovc_evt)
    );

    ulev_line_mon #(.QUAL(QUAL)) u_line (
        .clk        (clk),
        .rst        (rst),
        .line_s     (line_s),
        .port_st    (port_st),
        .bchg_evt   (bchg_evt),
        .attach_evt (attach_evt),
        .detach_evt (detach_evt)
    );

    assign evts = '{attach: attach_evt, detach: detach_evt, bchg: bchg_evt, ovc: ovc_evt};

    assign wsel    = wsel_t'(wr_sel_i);
    assign en_we   = wr_en_i && (wsel == WSEL_ENABLE);
    assign clr_we  = wr_en_i && (wsel == WSEL_CLEAR);
    assign ctrl_we = wr_en_i && (wsel == WSEL_CTRL);

    ulev_irq_regs #(.N(NUM_EVT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .evt       (evts),
        .en_we     (en_we),
        .en_wdata  (wr_data_i),
        .clr_we    (clr_we),
        .clr_wdata (wr_data_i),
        .status    (status_o),
        .enable    (enable_o),
        .irq_n     (irq_n_o)
    );

    // port state: detach overrides both attach tracking and software control
    always_ff @(posedge clk) begin
        if (rst) begin
            port_st <= PORT_IDLE;
            uact    <= 1'b0;
        end else if (detach_evt) begin
            port_st <= PORT_IDLE;
            uact    <= 1'b0;
        end else begin
            if (attach_evt) port_st <= PORT_ATTACHED;
            if (ctrl_we)    uact    <= wr_data_i[0];
        end
    end

    assign line_mon_o    = line_s;
    assign ovc_mon_o     = ovc_s;
    assign port_active_o = uact;
    assign port_idle_o   = (port_st == PORT_IDLE);
endmodule

// File: rtl/ulev_checker.sv
module ulev_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [1:0] wr_sel_i,
    input logic [3:0] wr_data_i,
    input logic       irq_n_o,
    input logic [1:0] line_mon_o,
    input logic [3:0] status_o,
    input logic [3:0] enable_o,
    input logic       port_active_o,
    input logic       port_idle_o,
    input logic       ovc_evt,
    input logic       bchg_evt,
    input logic       attach_evt,
    input logic       detach_evt
);
    assert_ovc_sets_R1: assert property (@(posedge clk) disable iff (rst)
        ovc_evt |=> status_o[0]);

    assert_bchg_no_se1_R3: assert property (@(posedge clk) disable iff (rst)
        bchg_evt |-> (line_mon_o != 2'b11));

    assert_attach_stable_R5: assert property (@(posedge clk) disable iff (rst)
        attach_evt |-> ($stable(line_mon_o) && (line_mon_o == 2'b01 || line_mon_o == 2'b10)));

    assert_detach_idle_R6: assert property (@(posedge clk) disable iff (rst)
        detach_evt |=> (!port_active_o && port_idle_o && status_o[2]));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
        irq_n_o == !(|(status_o & enable_o)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 2'b01 && !wr_data_i[1] && !bchg_evt) |=> !status_o[1]);

    assert_attach_gate_R9: assert property (@(posedge clk) disable iff (rst)
        attach_evt |-> port_idle_o);
endmodule

bind usb_port_line_irq ulev_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .irq_n_o       (irq_n_o),
    .line_mon_o    (line_mon_o),
    .status_o      (status_o),
    .enable_o      (enable_o),
    .port_active_o (port_active_o),
    .port_idle_o   (port_idle_o),
    .ovc_evt       (ovc_evt),
    .bchg_evt      (bchg_evt),
    .attach_evt    (attach_evt),
    .detach_evt    (detach_evt)
);

// File: tb/usb_port_line_irq_test.sv
module usb_port_line_irq_test;
    localparam int Q = 125000000 / 400000;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] line_i;
    logic       ovc_a_i, ovc_b_i;
    logic       wr_en_i;
    logic [1:0] wr_sel_i;
    logic [3:0] wr_data_i;
    logic       irq_n_o;
    logic [1:0] line_mon_o, ovc_mon_o;
    logic [3:0] status_o, enable_o;
    logic       port_active_o, port_idle_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    usb_port_line_irq uut (
        .clk           (clk),
        .rst           (rst),
        .line_i        (line_i),
        .ovc_a_i       (ovc_a_i),
        .ovc_b_i       (ovc_b_i),
        .wr_en_i       (wr_en_i),
        .wr_sel_i      (wr_sel_i),
        .wr_data_i     (wr_data_i),
        .irq_n_o       (irq_n_o),
        .line_mon_o    (line_mon_o),
        .ovc_mon_o     (ovc_mon_o),
        .status_o      (status_o),
        .enable_o      (enable_o),
        .port_active_o (port_active_o),
        .port_idle_o   (port_idle_o)
    );

    function automatic logic fs_move(input logic [1:0] a, input logic [1:0] b);
        return (a != b) && (a != 2'b11) && (b != 2'b11);
    endfunction

    function automatic logic jk(input logic [1:0] v);
        return (v == 2'b01) || (v == 2'b10);
    endfunction

    function automatic logic exp_irq_n(input logic [3:0] st, input logic [3:0] en);
        return !(|(st & en));
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] data);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = data;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] cur;
        logic       idle_m, uact_m;
        void'($urandom(32'd4242));
        rst = 1'b1; line_i = 2'b00; ovc_a_i = 1'b0; ovc_b_i = 1'b0;
        wr_en_i = 1'b0; wr_sel_i = 2'b00; wr_data_i = 4'h0;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R10 reset state
        chk("R10 status", status_o, 4'h0);
        chk("R10 enable", enable_o, 4'h0);
        chk("R10 irq_n", irq_n_o, 1'b1);
        chk("R10 idle", port_idle_o, 1'b1);
        chk("R10 active", port_active_o, 1'b0);
        chk("R10 monitors", {line_mon_o, ovc_mon_o}, 4'h0);

        // R1/R2 rising edge on pin A, falling edge on pin B
        ovc_a_i = 1'b1;
        tick(2);
        chk("R2 ovc monitor", ovc_mon_o, 2'b01);
        tick(2);
        chk("R1 ovc rise", status_o[0], 1'b1);
        wr(2'b01, 4'h0);
        chk("R8 clear", status_o, 4'h0);
        ovc_b_i = 1'b1; tick(5); wr(2'b01, 4'h0);
        ovc_b_i = 1'b0;
        tick(5);
        chk("R1 ovc fall on B", status_o[0], 1'b1);
        chk("R2 ovc monitor B low", ovc_mon_o, 2'b01);

        // R8 clear versus same-cycle event sweep
        for (int off = 0; off < 6; off++) begin
            ovc_a_i = ~ovc_a_i;
            tick(off);
            wr(2'b01, 4'h0);
            tick(4);
            chk($sformatf("R8 race offset %0d", off), status_o[0], (off <= 2) ? 1'b1 : 1'b0);
        end

        // R11/R7 enable and interrupt level
        ovc_a_i = ~ovc_a_i; tick(5);
        wr(2'b00, 4'b0001);
        chk("R11 enable load", enable_o, 4'b0001);
        chk("R7 irq asserted", irq_n_o, 1'b0);
        wr(2'b00, 4'b1110);
        chk("R7 irq masked", irq_n_o, 1'b1);
        wr(2'b00, 4'b0000);
        wr(2'b01, 4'h0);

        // R5/R4/R3 attach from SE0 into J, exact window
        line_i = 2'b01;
        tick(3);
        chk("R4 line monitor J", line_mon_o, 2'b01);
        chk("R3 bchg SE0->J", status_o[1], 1'b1);
        tick(Q - 3);
        chk("R5 attach not early", status_o[3], 1'b0);
        tick(6);
        chk("R5 attach set", status_o[3], 1'b1);
        chk("R5 port left idle", port_idle_o, 1'b0);
        wr(2'b10, 4'b0001);
        chk("R11 port active set", port_active_o, 1'b1);

        // R8 write-one keeps, write-zero clears
        ovc_a_i = ~ovc_a_i; tick(5);
        wr(2'b01, 4'b1101);
        chk("R8 selective clear", status_o, 4'b1001);
        wr(2'b01, 4'h0);

        // R9 attached: J->K->J with long holds, no attach
        line_i = 2'b10; tick(Q + 20);
        chk("R9 no attach on K", status_o[3], 1'b0);
        chk("R3 bchg J->K", status_o[1], 1'b1);
        line_i = 2'b01; tick(Q + 20);
        chk("R9 no attach on J", status_o[3], 1'b0);
        wr(2'b01, 4'h0);

        // R3 moves through SE1 do not set bus change
        line_i = 2'b11; tick(10);
        chk("R3 J->SE1 ignored", status_o[1], 1'b0);
        line_i = 2'b10; tick(10);
        chk("R3 SE1->K ignored", status_o[1], 1'b0);
        chk("R4 line monitor K", line_mon_o, 2'b10);

        // R6 detach with enables off
        wr(2'b01, 4'h0);
        line_i = 2'b00; tick(Q + 10);
        chk("R6 detach set", status_o[2], 1'b1);
        chk("R6 active cleared", port_active_o, 1'b0);
        chk("R6 idle", port_idle_o, 1'b1);
        chk("R7 irq stays high", irq_n_o, 1'b1);
        wr(2'b01, 4'h0);

        // R5 attach from SE1 into K
        line_i = 2'b11; tick(10);
        line_i = 2'b10; tick(Q + 10);
        chk("R5 attach from SE1", status_o[3], 1'b1);
        chk("R3 no bchg via SE1", status_o[1], 1'b0);
        wr(2'b01, 4'h0);

        // random sequences against the bench model
        cur = 2'b10; idle_m = 1'b0; uact_m = 1'b0;
        for (int s = 0; s < 40; s++) begin
            logic [1:0] nv;
            logic [3:0] en, exp;
            logic       tog, lng, pinb;
            int         hold;
            nv   = 2'($urandom_range(0, 3));
            if (nv == cur) nv = nv + 2'd1;
            tog  = 1'($urandom_range(0, 1));
            pinb = 1'($urandom_range(0, 1));
            lng  = 1'($urandom_range(0, 1));
            hold = lng ? (Q + 10 + $urandom_range(0, 30)) : (6 + $urandom_range(0, Q - 40));
            en   = 4'($urandom_range(0, 15));
            wr(2'b00, en);
            exp = 4'h0;
            if (fs_move(cur, nv)) exp[1] = 1'b1;
            if (tog) exp[0] = 1'b1;
            if (lng) begin
                if (idle_m && jk(nv)) begin
                    exp[3] = 1'b1; idle_m = 1'b0;
                end else if (!idle_m && nv == 2'b00) begin
                    exp[2] = 1'b1; idle_m = 1'b1; uact_m = 1'b0;
                end
            end
            line_i = nv;
            if (tog) begin
                if (pinb) ovc_b_i = ~ovc_b_i;
                else      ovc_a_i = ~ovc_a_i;
            end
            tick(hold + 4);
            chk($sformatf("R1 R3 R5 R6 R9 random status step %0d", s), status_o, exp);
            chk($sformatf("R7 random irq step %0d", s), irq_n_o, exp_irq_n(exp, en));
            chk($sformatf("R5 R6 random idle step %0d", s), port_idle_o, idle_m);
            chk($sformatf("R6 R11 random active step %0d", s), port_active_o, uact_m);
            chk($sformatf("R4 random line monitor step %0d", s), line_mon_o, nv);
            chk($sformatf("R2 random ovc monitor step %0d", s), ovc_mon_o, {ovc_b_i, ovc_a_i});
            wr(2'b01, 4'h0);
            chk($sformatf("R8 random clear step %0d", s), status_o, 4'h0);
            if (!idle_m && $urandom_range(0, 1) == 1) begin
                wr(2'b10, 4'b0001);
                uact_m = 1'b1;
            end
            cur = nv;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule